// File: doc/BRIEF.md
# I2C Slave Receive Engine with 7/10-bit Addressing

This block is the receive side of an I2C target. It watches SCL and SDA, which have already been brought into the system clock domain. It waits for a START, shifts in each byte MSB first on the rising edges of SCL, and checks the address phase against a host-programmed address register. In 7-bit mode one address byte is checked. In 10-bit mode two address bytes are checked, and the host reprograms the address register between them.

Every accepted byte, whether an address or data, is copied into a one-entry receive buffer. The acknowledge is granted only when that buffer is empty and no overflow is pending. A refused byte raises a sticky overflow flag and is not acknowledged. The interrupt flag rises on the falling edge of the ninth SCL pulse of every byte the block has taken part in.

After each 10-bit address byte the block holds SCL low until the host writes the address register. The host uses simple strobes to write the address, pop the buffer, and clear the interrupt and overflow flags. The bus outputs are open-drain enables: a 1 means pull the line low.

Top module: `i2c_slave_rx`

## Requirements
- R1: While `en` is low, or after `en` rises and before any START (SDA falling while SCL is high), bus activity draws no ACK and sets no flag.
- R2: Data bits are sampled on SCL rising edges, MSB first, and an accepted byte appears unchanged on `rx_data`.
- R3: In 7-bit mode (`ten_bit`=0) the first byte after a START matches when its bits [7:1] equal address register bits [7:1] and its bit 0 (read/write) is 0. On a match with both flags clear, `sda_oe` is 1 from the 8th SCL falling edge to the 9th SCL falling edge, the byte is loaded into `rx_data`, and `buf_full` is set.
- R4: On an address mismatch, including a read request (bit 0 = 1), there is no ACK and no flag is set, and every later byte is ignored until the next START.
- R5: `irq` is set at the 9th SCL falling edge of every matched-address or data byte, whether or not that byte was acknowledged. It stays set until an `irq_clr` strobe.
- R6: If `buf_full` or `overflow` is set when a byte completes, the byte is neither loaded nor acknowledged, and the block ignores the bus until the next START. If `buf_full`=1 and `overflow`=0, `overflow` is set.
- R7: `overflow` stays set until an `ovf_clr` strobe. Reading the buffer does not clear it.
- R8: A `buf_rd` strobe clears `buf_full`.
- R9: In 10-bit mode the first address byte matches only when its top five bits are 11110, its bit 0 is 0, and its bits [7:1] equal address register bits [7:1].
- R10: In 10-bit mode, after each acknowledged address byte, `upd_addr` and `scl_oe` are set at the 9th SCL falling edge. An `addr_we` strobe clears `upd_addr` and releases `scl_oe`.
- R11: In 10-bit mode the second address byte must equal all 8 bits of the address register.
- R12: A STOP (SDA rising while SCL is high) returns the block to idle, so later bytes are ignored until a START. A repeated START makes the next byte an address byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable for the bus engine |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address register write value |
| buf_rd | input | 1 | Receive buffer read strobe |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer or overflow flag was set |
| irq | output | 1 | Interrupt flag |
| upd_addr | output | 1 | Host must rewrite the address register (10-bit mode) |

## Verification
`sda_oe`, `rx_data`, `buf_full` and `overflow` change on the first clock edge that sees SCL low after the 8th high pulse. `irq`, `upd_addr` and `scl_oe` change on the first edge that sees the 9th SCL low. Host strobes take effect one edge after they are applied.

The bench drives all stimulus on falling clock edges and holds each SCL phase for several clocks. It samples the ACK in the middle of the 9th high phase and reads the flags a few clocks after the final falling edge, so each value is read well after it has settled. The interrupt flag is also read during the 9th high phase, to confirm it has not yet risen.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int PREFIX_W = 5;
  localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR1,
    PH_ADDR2,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
(
  input  phase_t            phase,
  input  logic              ten_bit,
  input  logic [BYTE_W-1:0] shift_q,
  input  logic [BYTE_W-1:0] addr_q,
  output logic              hit
);
  logic wr_ok, upper_eq, prefix_ok, full_eq;

  always_comb begin
    wr_ok     = ~shift_q[0];
    upper_eq  = (shift_q[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);
    prefix_ok = (shift_q[BYTE_W-1:BYTE_W-PREFIX_W] == TEN_PREFIX);
    full_eq   = (shift_q == addr_q);
    hit       = 1'b0;
    case (phase)
      PH_ADDR1: hit = wr_ok & upper_eq & (prefix_ok | ~ten_bit);
      PH_ADDR2: hit = full_eq;
      PH_DATA:  hit = 1'b1;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  input  logic              ev_load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              ev_ovf,
  input  logic              ev_irq,
  input  logic              ev_upd,
  output logic [BYTE_W-1:0] addr_q,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              overflow,
  output logic              irq,
  output logic              upd_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      rx_data  <= '0;
      buf_full <= 1'b0;
      overflow <= 1'b0;
      irq      <= 1'b0;
      upd_addr <= 1'b0;
    end else begin
      if (addr_we) addr_q <= addr_wdata;
      if (ev_load) rx_data <= load_data;

      if (ev_load)     buf_full <= 1'b1;
      else if (buf_rd) buf_full <= 1'b0;

      if (ev_ovf)       overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;

      if (ev_irq)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (ev_upd)       upd_addr <= 1'b1;
      else if (addr_we) upd_addr <= 1'b0;
    end
  end

  // R7: overflow holds until its own clear strobe
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow && !ovf_clr |=> overflow);

  // R5: interrupt flag holds until cleared
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq);

  // R2: an accepted byte lands in the buffer and marks it full
  a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> buf_full && (rx_data == $past(load_data)));

  // R6: a full buffer is never overwritten
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    buf_full |=> $stable(rx_data));

  // R10: an address write clears the update request
  a_r10_upd_clear: assert property (@(posedge clk) disable iff (rst)
    addr_we && !ev_upd |=> !upd_addr);
endmodule

// File: rtl/i2cs_rx_fsm.sv
module i2cs_rx_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ten_bit,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic              bf_i,
  input  logic              ovf_i,
  input  logic              addr_wr,
  output phase_t            phase,
  output logic [BYTE_W-1:0] shift_q,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              ev_load,
  output logic              ev_ovf,
  output logic              ev_irq,
  output logic              ev_upd
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             ack_pend;
  logic             irq_pend;
  logic             at_8th, at_9th, accept, addr_phase;

  always_comb begin
    at_8th     = scl_fall && (bit_cnt == LAST_BIT) && (phase != PH_IDLE);
    at_9th     = scl_fall && (bit_cnt == ACK_BIT) && (phase != PH_IDLE);
    accept     = at_8th && hit && !bf_i && !ovf_i;
    addr_phase = (phase == PH_ADDR1) || (phase == PH_ADDR2);
    ev_load    = accept;
    ev_ovf     = at_8th && hit && bf_i && !ovf_i;
    ev_irq     = at_9th && irq_pend;
    ev_upd     = at_9th && ack_pend && ten_bit && addr_phase;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shift_q  <= '0;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      ack_pend <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (start_det || stop_det) begin
        phase    <= start_det ? PH_ADDR1 : PH_IDLE;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        scl_oe   <= 1'b0;
        ack_pend <= 1'b0;
        irq_pend <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && (bit_cnt < LAST_BIT)) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_i};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
        if (at_8th) begin
          bit_cnt  <= ACK_BIT;
          irq_pend <= hit;
          ack_pend <= accept;
          sda_oe   <= accept;
          if (!hit) phase <= PH_IDLE;
        end
        if (at_9th) begin
          bit_cnt  <= '0;
          sda_oe   <= 1'b0;
          irq_pend <= 1'b0;
          ack_pend <= 1'b0;
          if (!ack_pend) begin
            phase <= PH_IDLE;
          end else if (phase == PH_ADDR1) begin
            phase  <= ten_bit ? PH_ADDR2 : PH_DATA;
            scl_oe <= ten_bit;
          end else if (phase == PH_ADDR2) begin
            phase  <= PH_DATA;
            scl_oe <= 1'b1;
          end else begin
            phase <= PH_DATA;
          end
        end
      end
      if (addr_wr) scl_oe <= 1'b0;
    end
  end

  // R6: ACK is only granted when the host flags were both clear
  a_r6_ack_needs_free: assert property (@(posedge clk) disable iff (rst || !en)
    $rose(sda_oe) |-> $past(!bf_i && !ovf_i));

  // R3: SDA drive changes only after an SCL fall, a bus condition or disable
  a_r3_sda_at_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det || !en));

  // R10: an address write releases the stretched clock
  a_r10_release: assert property (@(posedge clk) disable iff (rst || !en)
    scl_oe && addr_wr |=> !scl_oe);

  // R12: STOP puts the engine back to idle with the bus released
  a_r12_stop_idle: assert property (@(posedge clk) disable iff (rst || !en)
    stop_det |=> (phase == PH_IDLE) && !sda_oe && !scl_oe);

  // R4: nothing is driven while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst || !en)
    (phase == PH_IDLE) |-> !sda_oe && !scl_oe);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ten_bit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_we,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              overflow,
  output logic              irq,
  output logic              upd_addr
);
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              hit;
  logic              ev_load, ev_ovf, ev_irq, ev_upd;
  logic [BYTE_W-1:0] shift_q, addr_q;
  phase_t            phase;

  i2cs_cond_det u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_addr_match u_match (
    .phase   (phase),
    .ten_bit (ten_bit),
    .shift_q (shift_q),
    .addr_q  (addr_q),
    .hit     (hit)
  );

  i2cs_rx_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ten_bit   (ten_bit),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .hit       (hit),
    .bf_i      (buf_full),
    .ovf_i     (overflow),
    .addr_wr   (addr_we),
    .phase     (phase),
    .shift_q   (shift_q),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe),
    .ev_load   (ev_load),
    .ev_ovf    (ev_ovf),
    .ev_irq    (ev_irq),
    .ev_upd    (ev_upd)
  );

  i2cs_host_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr_we    (addr_we),
    .addr_wdata (addr_wdata),
    .buf_rd     (buf_rd),
    .irq_clr    (irq_clr),
    .ovf_clr    (ovf_clr),
    .ev_load    (ev_load),
    .load_data  (shift_q),
    .ev_ovf     (ev_ovf),
    .ev_irq     (ev_irq),
    .ev_upd     (ev_upd),
    .addr_q     (addr_q),
    .rx_data    (rx_data),
    .buf_full   (buf_full),
    .overflow   (overflow),
    .irq        (irq),
    .upd_addr   (upd_addr)
  );
endmodule

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       ten_bit = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       scl_line, sda_line;
  logic       scl_oe, sda_oe;
  logic       addr_we = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic       buf_rd = 1'b0;
  logic       irq_clr = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, overflow, irq, upd_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit ack_s, irq_mid;

  always #(CLK_P/2) clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_slave_rx u_dut (
    .clk(clk), .rst(rst), .en(en), .ten_bit(ten_bit),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .buf_rd(buf_rd),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_data(rx_data),
    .buf_full(buf_full), .overflow(overflow), .irq(irq), .upd_addr(upd_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    for (int k = 0; k < 2000 && scl_line !== 1'b1; k++) @(negedge clk);
    wait_n(HALF);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_n(HALF);
    scl_high();
    m_sda = 1'b0; wait_n(HALF);
    m_scl = 1'b0; wait_n(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(HALF);
    scl_high();
    m_sda = 1'b1; wait_n(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    m_scl = 1'b0; wait_n(HALF);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_n(HALF);
      scl_high();
      m_scl = 1'b0; wait_n(HALF);
    end
    m_sda = 1'b1; wait_n(HALF);
    m_scl = 1'b1; wait_n(HALF);
    ack_s   = (sda_line == 1'b0);
    irq_mid = irq;
    wait_n(HALF);
    m_scl = 1'b0; wait_n(HALF);
  endtask

  task automatic pulse(input int which, input logic [7:0] v);
    @(negedge clk);
    case (which)
      0: begin addr_we = 1'b1; addr_wdata = v; end
      1: buf_rd  = 1'b1;
      2: irq_clr = 1'b1;
      default: ovf_clr = 1'b1;
    endcase
    @(negedge clk);
    addr_we = 1'b0; buf_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
    wait_n(2);
  endtask

  task automatic t_reset();
    chk("reset buf_full", buf_full, 0);
    chk("reset overflow", overflow, 0);
    chk("reset irq", irq, 0);
    chk("reset sda_oe/scl_oe/upd", {sda_oe, scl_oe, upd_addr}, 0);
  endtask

  task automatic t_enable_gate();
    pulse(0, 8'h50);
    bus_start(); send_byte(8'h50);
    chk("R1 disabled no ack", ack_s, 0);
    bus_stop();
    @(negedge clk); en = 1'b1; wait_n(4);
    send_byte(8'h50);
    chk("R1 no START no ack", ack_s, 0);
    chk("R1 no START flags", {buf_full, irq}, 0);
    bus_stop();
  endtask

  task automatic t_basic_7bit();
    bus_start(); send_byte(8'h50);
    chk("R3 address ack", ack_s, 1);
    chk("R5 irq low before 9th fall", irq_mid, 0);
    chk("R3 address in buffer", rx_data, 8'h50);
    chk("R3 buf_full set", buf_full, 1);
    chk("R5 irq after 9th fall", irq, 1);
    pulse(1, 0);
    chk("R8 read clears buf_full", buf_full, 0);
    pulse(2, 0);
    chk("R5 irq cleared", irq, 0);
    send_byte(8'hC6);
    chk("R2 data ack", ack_s, 1);
    chk("R2 data MSB first", rx_data, 8'hC6);
    pulse(2, 0);
    send_byte(8'h3C);
    chk("R6 full buffer nack", ack_s, 0);
    chk("R6 overflow set", overflow, 1);
    chk("R6 buffer kept", rx_data, 8'hC6);
    chk("R5 irq on refused byte", irq, 1);
    bus_stop();
    pulse(2, 0); pulse(1, 0);
    chk("R7 overflow survives read", overflow, 1);
    bus_start(); send_byte(8'h50);
    chk("R6 ovf-only nack", ack_s, 0);
    chk("R6 ovf-only irq, no load", {irq, buf_full}, 2'b10);
    bus_stop();
    pulse(3, 0);
    chk("R7 ovf_clr clears", overflow, 0);
    pulse(2, 0);
    bus_start(); send_byte(8'h50);
    chk("R3 ack after clear", ack_s, 1);
    send_byte(8'h01);
    chk("R6 bf-only nack", ack_s, 0);
    bus_stop(); pulse(2, 0);
    bus_start(); send_byte(8'h50);
    chk("R6 bf+ovf nack", ack_s, 0);
    chk("R6 bf+ovf flags", {buf_full, overflow, irq}, 3'b111);
    chk("R6 bf+ovf buffer kept", rx_data, 8'h50);
    bus_stop();
    pulse(3, 0); pulse(1, 0); pulse(2, 0);
  endtask

  task automatic t_mismatch();
    bus_start(); send_byte(8'h52);
    chk("R4 mismatch nack", ack_s, 0);
    chk("R4 mismatch no flags", {buf_full, irq, overflow}, 0);
    send_byte(8'h50);
    chk("R4 later byte ignored", ack_s, 0);
    chk("R4 later byte no load", buf_full, 0);
    bus_stop();
    bus_start(); send_byte(8'h51);
    chk("R4 read request refused", {ack_s, irq}, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    bus_start(); send_byte(8'h50);
    pulse(1, 0); pulse(2, 0);
    send_byte(8'h11);
    chk("R12 data before restart", rx_data, 8'h11);
    pulse(1, 0); pulse(2, 0);
    bus_start(); send_byte(8'h11);
    chk("R12 restart makes address phase", {ack_s, irq}, 0);
    bus_start(); send_byte(8'h50);
    chk("R12 restart address ack", ack_s, 1);
    pulse(1, 0); pulse(2, 0);
    bus_stop();
    send_byte(8'h50);
    chk("R12 after STOP ignored", {ack_s, buf_full}, 0);
    bus_stop();
  endtask

  task automatic t_ten_bit();
    @(negedge clk); ten_bit = 1'b1;
    pulse(0, 8'hF4);
    bus_start(); send_byte(8'hF4);
    chk("R9 first byte ack", ack_s, 1);
    chk("R10 upd and stretch", {upd_addr, scl_oe, buf_full, irq}, 4'hF);
    chk("R9 first byte buffered", rx_data, 8'hF4);
    pulse(1, 0); pulse(2, 0);
    pulse(0, 8'hA5);
    chk("R10 write releases", {upd_addr, scl_oe}, 0);
    send_byte(8'hA5);
    chk("R11 second byte ack", ack_s, 1);
    chk("R10 second stretch", {upd_addr, scl_oe}, 2'b11);
    chk("R11 second byte buffered", rx_data, 8'hA5);
    pulse(1, 0); pulse(2, 0);
    pulse(0, 8'hF4);
    chk("R10 restore releases", {upd_addr, scl_oe}, 0);
    send_byte(8'h77);
    chk("R2 10-bit data ack", ack_s, 1);
    chk("R10 no stretch on data", {rx_data, upd_addr, scl_oe}, {8'h77, 2'b00});
    pulse(1, 0); pulse(2, 0);
    bus_stop();
    bus_start(); send_byte(8'hF6);
    chk("R9 wrong high bits nack", {ack_s, irq}, 0);
    bus_stop();
    pulse(0, 8'hE4);
    bus_start(); send_byte(8'hE4);
    chk("R9 wrong prefix nack", {ack_s, irq}, 0);
    bus_stop();
    pulse(0, 8'hF4);
    bus_start(); send_byte(8'hF4);
    pulse(1, 0); pulse(2, 0);
    pulse(0, 8'hA4);
    send_byte(8'hA5);
    chk("R11 low byte mismatch nack", {ack_s, buf_full, upd_addr, scl_oe}, 0);
    bus_stop();
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    t_reset();
    t_enable_gate();
    t_basic_7bit();
    t_mismatch();
    t_restart();
    t_ten_bit();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule